// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the eight-bit status word of a small processor core. Its low four bits are arithmetic flags: carry, auxiliary (nibble) carry, zero and overflow. Each is loaded from the current ALU operation when that operation's per-flag update enable is raised. Software may also write these four bits through a write port. When a software write and an ALU update land in the same cycle, the ALU update wins for every flag the operation touches.

Bits 4 and 5 are system flags, named power-down and watchdog time-out. Only decoded hardware event strobes can change them: a watchdog expiry, the clear-watchdog instruction and the halt instruction. Software writes and ALU results never reach them. Bits 6 and 7 always read as zero. Every change appears on the output one clock after the cycle that causes it.

Top module: `status_flags`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it goes low, `status_q` becomes 8'h00.
- R2: When `flag_upd[0]` is high, bit 0 (carry) takes the value of `alu_cout` on the next edge.
- R3: When `flag_upd[1]` is high, bit 1 (auxiliary carry) takes the value of `alu_nib_cout` on the next edge.
- R4: When `flag_upd[2]` is high, bit 2 (zero) becomes 1 if `alu_res` is all zeros, and 0 otherwise.
- R5: When `flag_upd[3]` is high, bit 3 (overflow) becomes `alu_msb_cin` XOR `alu_cout`.
- R6: When `sw_we` is high, bits 3:0 load `sw_wdata[3:0]`, except for each bit whose `flag_upd` bit is also high; that bit takes the ALU value.
- R7: A software write never changes bit 4 or bit 5.
- R8: Bit 4 (power-down) is set by `evt_halt` and cleared by `evt_clr_wdt`. When both strobes are high, the set wins.
- R9: Bit 5 (time-out) is set by `evt_wdt_timeout` and cleared by `evt_clr_wdt` or `evt_halt`. When the time-out and a clear source are high together, the time-out wins.
- R10: Bits 7:6 of `status_q` always read 0, including after a write of 8'hFF.
- R11: A flag holds its value when no update, write or event touches it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| alu_res | input | 8 | Result of the current ALU operation |
| alu_cout | input | 1 | Carry out of the MSB, or no-borrow in subtraction, or rotate bit |
| alu_msb_cin | input | 1 | Carry into the MSB |
| alu_nib_cout | input | 1 | Carry out of the low nibble, or no nibble borrow |
| flag_upd | input | 4 | Per-flag ALU update enables: bit 0 carry, 1 aux carry, 2 zero, 3 overflow |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 8 | Software write data |
| evt_wdt_timeout | input | 1 | Watchdog time-out strobe |
| evt_clr_wdt | input | 1 | Clear-watchdog instruction strobe |
| evt_halt | input | 1 | Halt instruction strobe |
| status_q | output | 8 | Status register value |

## Verification
The assertions assume that every input is a known level at each sampled edge and that inputs are held at zero during reset. The single-cycle `$past` checks rely on this. They place no limit on strobe combinations, so the bench deliberately drives overlapping events, write-with-update cycles and simultaneous event strobes. The bench changes inputs only shortly after a rising edge, and it drives every port to a defined value from time zero.

// File: rtl/status_pkg.sv
// Package: shared constants and types for the status flag register.
// Assumes an 8-bit register with arithmetic flags in the low bits.
package status_pkg;
    localparam int REG_W    = 8;
    localparam int DATA_W   = 8;
    localparam int ARITH_N  = 4;
    localparam int C_BIT    = 0;
    localparam int AC_BIT   = 1;
    localparam int Z_BIT    = 2;
    localparam int OV_BIT   = 3;
    localparam int PDF_BIT  = 4;
    localparam int TO_BIT   = 5;
    localparam int PAD_W    = REG_W - TO_BIT - 1;

    typedef struct packed {
        logic tmo;
        logic clr;
        logic halt;
    } sys_evt_t;
endpackage

// File: rtl/sr_alu_flag_calc.sv
// Module: derives the four candidate arithmetic flag values from ALU outputs.
// Assumes the ALU supplies carry-out, carry-into-MSB and nibble carry directly.
module sr_alu_flag_calc #(
    parameter int DATA_W  = status_pkg::DATA_W,
    parameter int ARITH_N = status_pkg::ARITH_N
) (
    input  logic [DATA_W-1:0]  alu_res,
    input  logic               alu_cout,
    input  logic               alu_msb_cin,
    input  logic               alu_nib_cout,
    output logic [ARITH_N-1:0] cand
);
    import status_pkg::*;

    // Combine ALU indicators into per-flag candidate values.
    always_comb begin
        cand         = '0;
        cand[C_BIT]  = alu_cout;
        cand[AC_BIT] = alu_nib_cout;
        cand[Z_BIT]  = ~(|alu_res);
        cand[OV_BIT] = alu_msb_cin ^ alu_cout;
    end
endmodule

// File: rtl/sr_arith_bits.sv
// Module: bank of software-writable arithmetic flags.
// Each bit prefers its ALU update over a software write, else holds.
module sr_arith_bits #(
    parameter int N = status_pkg::ARITH_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] upd,
    input  logic [N-1:0] cand,
    input  logic         we,
    input  logic [N-1:0] wval,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // One flag: reset, ALU update, software write, hold.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= 1'b0;
            else if (upd[i])
                q[i] <= cand[i];
            else if (we)
                q[i] <= wval[i];
        end
    end
endmodule

// File: rtl/sr_sys_bits.sv
// Module: power-down and time-out flags driven only by system event strobes.
// Assumes strobes are single-cycle decoded pulses; no software path exists.
module sr_sys_bits (
    input  logic                  clk,
    input  logic                  rst_n,
    input  status_pkg::sys_evt_t  evt,
    output logic                  pdf_q,
    output logic                  to_q
);
    // Power-down flag: halt sets (wins), clear-watchdog clears.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pdf_q <= 1'b0;
        else if (evt.halt)
            pdf_q <= 1'b1;
        else if (evt.clr)
            pdf_q <= 1'b0;
    end

    // Time-out flag: expiry sets (wins), clear-watchdog or halt clears.
    always_ff @(posedge clk) begin
        if (!rst_n)
            to_q <= 1'b0;
        else if (evt.tmo)
            to_q <= 1'b1;
        else if (evt.clr || evt.halt)
            to_q <= 1'b0;
    end
endmodule

// File: rtl/status_flags.sv
// Module: top of the status flag register.
// Assembles arithmetic flags, system flags and zero padding into one word.
module status_flags #(
    parameter int DATA_W = status_pkg::DATA_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [DATA_W-1:0]             alu_res,
    input  logic                          alu_cout,
    input  logic                          alu_msb_cin,
    input  logic                          alu_nib_cout,
    input  logic [status_pkg::ARITH_N-1:0] flag_upd,
    input  logic                          sw_we,
    input  logic [status_pkg::REG_W-1:0]  sw_wdata,
    input  logic                          evt_wdt_timeout,
    input  logic                          evt_clr_wdt,
    input  logic                          evt_halt,
    output logic [status_pkg::REG_W-1:0]  status_q
);
    import status_pkg::*;

    logic [ARITH_N-1:0] cand;
    logic [ARITH_N-1:0] arith_q;
    logic               pdf_q;
    logic               to_q;
    sys_evt_t           evt;
    logic               unused_wr_hi;

    // Upper write bits have no storage behind them.
    assign unused_wr_hi = ^sw_wdata[REG_W-1:ARITH_N];

    // Bundle the event strobes.
    always_comb begin
        evt.tmo  = evt_wdt_timeout;
        evt.clr  = evt_clr_wdt;
        evt.halt = evt_halt;
    end

    sr_alu_flag_calc #(.DATA_W(DATA_W), .ARITH_N(ARITH_N)) u_calc (
        .alu_res      (alu_res),
        .alu_cout     (alu_cout),
        .alu_msb_cin  (alu_msb_cin),
        .alu_nib_cout (alu_nib_cout),
        .cand         (cand)
    );

    sr_arith_bits #(.N(ARITH_N)) u_arith (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (flag_upd),
        .cand  (cand),
        .we    (sw_we),
        .wval  (sw_wdata[ARITH_N-1:0]),
        .q     (arith_q)
    );

    sr_sys_bits u_sys (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .pdf_q (pdf_q),
        .to_q  (to_q)
    );

    // Form the readable word; unused bits are tied low.
    assign status_q = {{PAD_W{1'b0}}, to_q, pdf_q, arith_q};
endmodule

// File: rtl/status_flags_chk.sv
// Checker: temporal properties of the status flag register, bound to the top.
// Assumes inputs are known at each edge and held at zero during reset.
module status_flags_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] alu_res,
    input logic       alu_cout,
    input logic       alu_msb_cin,
    input logic       alu_nib_cout,
    input logic [3:0] flag_upd,
    input logic       sw_we,
    input logic [7:0] sw_wdata,
    input logic       evt_wdt_timeout,
    input logic       evt_clr_wdt,
    input logic       evt_halt,
    input logic [7:0] status_q
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> status_q == 8'h00);
    assert_carry_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        flag_upd[0] |=> status_q[0] == $past(alu_cout));
    assert_aux_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flag_upd[1] |=> status_q[1] == $past(alu_nib_cout));
    assert_zero_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        flag_upd[2] |=> status_q[2] == ($past(alu_res) == 8'h00));
    assert_ovf_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flag_upd[3] |=> status_q[3] == ($past(alu_msb_cin) ^ $past(alu_cout)));
    assert_sw_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we && flag_upd == 4'h0) |=> status_q[3:0] == $past(sw_wdata[3:0]));
    assert_sys_untouched_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_wdt_timeout && !evt_clr_wdt && !evt_halt) |=> $stable(status_q[5:4]));
    assert_pdf_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evt_halt |=> status_q[4]);
    assert_pdf_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_clr_wdt && !evt_halt) |=> !status_q[4]);
    assert_to_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        evt_wdt_timeout |=> status_q[5]);
    assert_to_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_wdt_timeout && (evt_clr_wdt || evt_halt)) |=> !status_q[5]);
    assert_pad_zero_R10: assert property (@(posedge clk)
        status_q[7:6] == 2'b00);
    assert_arith_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_we && flag_upd == 4'h0) |=> $stable(status_q[3:0]));
endmodule

bind status_flags status_flags_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .alu_res         (alu_res),
    .alu_cout        (alu_cout),
    .alu_msb_cin     (alu_msb_cin),
    .alu_nib_cout    (alu_nib_cout),
    .flag_upd        (flag_upd),
    .sw_we           (sw_we),
    .sw_wdata        (sw_wdata),
    .evt_wdt_timeout (evt_wdt_timeout),
    .evt_clr_wdt     (evt_clr_wdt),
    .evt_halt        (evt_halt),
    .status_q        (status_q)
);

// File: tb/status_flags_test.sv
// Bench: directed scenarios for the status flag register, one task each.
module status_flags_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] alu_res = 8'h00;
    logic       alu_cout = 1'b0;
    logic       alu_msb_cin = 1'b0;
    logic       alu_nib_cout = 1'b0;
    logic [3:0] flag_upd = 4'h0;
    logic       sw_we = 1'b0;
    logic [7:0] sw_wdata = 8'h00;
    logic       evt_wdt_timeout = 1'b0;
    logic       evt_clr_wdt = 1'b0;
    logic       evt_halt = 1'b0;
    logic [7:0] status_q;

    int total = 0;
    int bad = 0;
    logic [7:0] model = 8'h00;

    status_flags uut (.*);

    // 100 MHz clock.
    always #5 clk = ~clk;

    // Return all stimulus to idle.
    task automatic idle();
        alu_res = 8'h00; alu_cout = 0; alu_msb_cin = 0; alu_nib_cout = 0;
        flag_upd = 4'h0; sw_we = 0; sw_wdata = 8'h00;
        evt_wdt_timeout = 0; evt_clr_wdt = 0; evt_halt = 0;
    endtask

    // Compare one value and log failures.
    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: status=%h expected=%h", req, act, exp);
        end
    endtask

    // Update the expected word from the current inputs, take one edge, check.
    task automatic step(input string req);
        logic [3:0] alu_v;
        logic [7:0] nm;
        alu_v = {alu_msb_cin ^ alu_cout, alu_res == 8'h00, alu_nib_cout, alu_cout};
        nm = model;
        if (!rst_n) nm = 8'h00;
        else begin
            for (int i = 0; i < 4; i++) begin
                if (flag_upd[i]) nm[i] = alu_v[i];
                else if (sw_we) nm[i] = sw_wdata[i];
            end
            if (evt_halt) nm[4] = 1'b1;
            else if (evt_clr_wdt) nm[4] = 1'b0;
            if (evt_wdt_timeout) nm[5] = 1'b1;
            else if (evt_clr_wdt || evt_halt) nm[5] = 1'b0;
            nm[7:6] = 2'b00;
        end
        model = nm;
        @(posedge clk);
        #2;
        check(req, status_q, model);
        idle();
    endtask

    task automatic t_reset();
        rst_n = 0; step("R1");
        step("R1");
        rst_n = 1;
        step("R1");
    endtask

    task automatic t_carry();
        flag_upd = 4'b0001; alu_cout = 1; step("R2");
        flag_upd = 4'b0001; alu_cout = 0; step("R2");
        flag_upd = 4'b0001; alu_cout = 1; alu_res = 8'h80; step("R2");
    endtask

    task automatic t_aux();
        flag_upd = 4'b0010; alu_nib_cout = 1; step("R3");
        flag_upd = 4'b0010; alu_nib_cout = 0; step("R3");
    endtask

    task automatic t_zero();
        flag_upd = 4'b0100; alu_res = 8'h00; step("R4");
        flag_upd = 4'b0100; alu_res = 8'h01; step("R4");
        flag_upd = 4'b0100; alu_res = 8'h80; step("R4");
    endtask

    task automatic t_ovf();
        flag_upd = 4'b1000; alu_msb_cin = 1; alu_cout = 0; step("R5");
        flag_upd = 4'b1000; alu_msb_cin = 1; alu_cout = 1; step("R5");
        flag_upd = 4'b1000; alu_msb_cin = 0; alu_cout = 1; step("R5");
        flag_upd = 4'b1111; alu_msb_cin = 0; alu_cout = 0; alu_nib_cout = 1; alu_res = 8'h00; step("R5");
    endtask

    task automatic t_write();
        sw_we = 1; sw_wdata = 8'h05; step("R6");
        sw_we = 1; sw_wdata = 8'h0A; step("R6");
        sw_we = 1; sw_wdata = 8'hFF; flag_upd = 4'b0101; alu_cout = 0; alu_res = 8'h33; step("R6");
    endtask

    task automatic t_sys_protect();
        evt_wdt_timeout = 1; step("R9");
        sw_we = 1; sw_wdata = 8'h00; step("R7");
        evt_halt = 1; step("R8");
        sw_we = 1; sw_wdata = 8'h20; step("R7");
        sw_we = 1; sw_wdata = 8'hFF; step("R10");
    endtask

    task automatic t_pdf();
        evt_clr_wdt = 1; step("R8");
        evt_halt = 1; step("R8");
        evt_halt = 1; evt_clr_wdt = 1; step("R8");
        evt_clr_wdt = 1; step("R8");
    endtask

    task automatic t_to();
        evt_wdt_timeout = 1; evt_clr_wdt = 1; step("R9");
        evt_halt = 1; step("R9");
        evt_wdt_timeout = 1; evt_halt = 1; step("R9");
        evt_clr_wdt = 1; step("R9");
    endtask

    task automatic t_hold();
        sw_we = 1; sw_wdata = 8'h0B; evt_wdt_timeout = 1; evt_halt = 1; step("R11");
        step("R11");
        step("R11");
    endtask

    task automatic t_reset_mid();
        rst_n = 0; step("R1");
        rst_n = 1; step("R1");
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #500000;
        total++; bad++;
        $display("FAIL watchdog: status=%h expected=done", status_q);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2;
        t_reset();
        t_carry();
        t_aux();
        t_zero();
        t_ovf();
        t_write();
        t_sys_protect();
        t_pdf();
        t_to();
        t_hold();
        t_reset_mid();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule